// File: doc/BRIEF.md
# Remote Key Serial Decoder

This block receives key codes from a wired remote control over a single asynchronous serial line. Each frame carries one byte and is sent least significant bit first. The frame has a low start bit and a high stop bit, with no parity. The receiver samples the line at sixteen times the bit rate. It checks each start bit halfway through the bit. It decides each data bit by a vote over the samples around the centre of the bit.

A byte is a key code only if its two top bits are set and exactly one of its six low bits is set. The low six bits are then the one-hot key identity. Any other byte is dropped without a trace.

The remote repeats the code while a button is held down. A cycle timer measures the gap since the last accepted key. When the same key comes back within the repeat window, the block signals a repeat. A different key, or the same key after a longer gap, is signalled as a new press. A frame whose stop bit reads low raises a framing-error pulse and produces no key.

Top module: `remkey_decoder`

## Requirements
- R1: The line is idle high. A frame has one start bit at 0, eight data bits with bit 0 first, and one stop bit. The line is sampled every CLK_HZ/(BAUD*16) cycles. The start bit is taken only if the line is still low at the centre sample of the start bit. A low pulse shorter than half a bit gives no frame.
- R2: Each data bit and the stop bit are decided by a majority of three consecutive samples at the bit centre. A one-sample disturbance inside a bit does not change the received byte.
- R3: A byte is a valid key when bits 7:6 are 11 and exactly one of bits 5:0 is 1. key_onehot then takes bits 5:0. The key codes are 0xC1 (bit 0, play), 0xC2 (bit 1, stop), 0xC4 (bit 2, minus), 0xC8 (bit 3, plus), 0xD0 (bit 4, volume up) and 0xE0 (bit 5, volume down).
- R4: A byte that is not a valid key raises no pulse. It changes neither key_onehot nor the gap timer.
- R5: A stop bit decided as 0 raises frame_err for exactly one cycle. The byte is dropped, with no key pulse and no change to key_onehot.
- R6: A valid key equal to key_onehot, arriving less than REPEAT_CYC cycles after the previous key event, raises key_repeat for one cycle.
- R7: Every other valid key raises key_press for one cycle. This covers a different key, or a gap of REPEAT_CYC cycles or more.
- R8: key_press and key_repeat are single-cycle pulses and never both high. key_onehot changes only in a cycle where one of them is high, and it holds the key of that event.
- R9: While rst_n is low, all outputs are 0 and the last-key memory is cleared. The first valid key after reset is a press.
- R10: The gap timer stops at REPEAT_CYC and does not wrap. However long the gap, a later same-key frame is a press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_line | input | 1 | Serial line from the remote, idle high, asynchronous |
| key_press | output | 1 | One-cycle pulse for a new key press |
| key_repeat | output | 1 | One-cycle pulse for a held-key repeat |
| key_onehot | output | 6 | Identity of the key of the latest event |
| frame_err | output | 1 | One-cycle pulse for a frame with a bad stop bit |

## Verification
The bound checker watches the output rules on every cycle:
- the two event pulses are exclusive and last one cycle;
- key_onehot is one-hot or zero;
- a framing error never coincides with a key;
- the repeat-or-press decision agrees with a gap counter kept inside the checker.

The serial side can only be shown by the bench's scenarios. Those scenarios cover start-bit glitch rejection, majority voting across a disturbed bit, and dropped unknown codes leaving the timer alone. They also cover saturation of the gap timer over long gaps, and the first frame after reset being a press.

// File: rtl/remkey_pkg.sv
package remkey_pkg;

  localparam int KEY_W  = 6;
  localparam int BYTE_W = 8;
  localparam int OVS    = 16;
  localparam logic [BYTE_W-KEY_W-1:0] KEY_PREFIX = '1;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/remkey_tick_gen.sv
module remkey_tick_gen #(
  parameter int unsigned DIV = 325
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          tick_n;

  always_comb begin
    if (cnt_q == LAST) begin
      cnt_n  = '0;
      tick_n = 1'b1;
    end else begin
      cnt_n  = cnt_q + 1'b1;
      tick_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      tick  <= tick_n;
    end
  end
endmodule

// File: rtl/remkey_uart_rx.sv
module remkey_uart_rx
  import remkey_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  output logic              byte_vld,
  output logic              stop_err,
  output logic [DATA_W-1:0] byte_data
);
  localparam int PH_W = $clog2(OVS);
  localparam int BC_W = $clog2(DATA_W);
  localparam logic [PH_W-1:0] PH_A    = PH_W'(OVS/2 - 1);
  localparam logic [PH_W-1:0] PH_B    = PH_W'(OVS/2);
  localparam logic [PH_W-1:0] PH_C    = PH_W'(OVS/2 + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

  rx_state_e         st_q, st_n;
  logic [PH_W-1:0]   ph_q, ph_n;
  logic [BC_W-1:0]   bc_q, bc_n;
  logic              sa_q, sa_n, sb_q, sb_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              vld_n, err_n;
  logic              vote;

  assign vote = maj3(sa_q, sb_q, rx);

  always_comb begin
    st_n  = st_q;
    ph_n  = ph_q;
    bc_n  = bc_q;
    sa_n  = sa_q;
    sb_n  = sb_q;
    sh_n  = sh_q;
    vld_n = 1'b0;
    err_n = 1'b0;
    if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (!rx) begin
            st_n = RX_START;
            ph_n = '0;
          end
        end
        RX_START: begin
          ph_n = ph_q + 1'b1;
          if (ph_q == PH_B && rx) begin
            st_n = RX_IDLE;
          end else if (ph_q == PH_LAST) begin
            st_n = RX_DATA;
            ph_n = '0;
            bc_n = '0;
          end
        end
        RX_DATA: begin
          ph_n = ph_q + 1'b1;
          if (ph_q == PH_A) sa_n = rx;
          if (ph_q == PH_B) sb_n = rx;
          if (ph_q == PH_C) sh_n = {vote, sh_q[DATA_W-1:1]};
          if (ph_q == PH_LAST) begin
            ph_n = '0;
            if (bc_q == BC_LAST) st_n = RX_STOP;
            else                 bc_n = bc_q + 1'b1;
          end
        end
        RX_STOP: begin
          ph_n = ph_q + 1'b1;
          if (ph_q == PH_A) sa_n = rx;
          if (ph_q == PH_B) sb_n = rx;
          if (ph_q == PH_C) begin
            vld_n = vote;
            err_n = ~vote;
            st_n  = RX_IDLE;
          end
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RX_IDLE;
      ph_q     <= '0;
      bc_q     <= '0;
      sa_q     <= 1'b1;
      sb_q     <= 1'b1;
      sh_q     <= '0;
      byte_vld <= 1'b0;
      stop_err <= 1'b0;
    end else begin
      st_q     <= st_n;
      ph_q     <= ph_n;
      bc_q     <= bc_n;
      sa_q     <= sa_n;
      sb_q     <= sb_n;
      sh_q     <= sh_n;
      byte_vld <= vld_n;
      stop_err <= err_n;
    end
  end

  assign byte_data = sh_q;
endmodule

// File: rtl/remkey_code_map.sv
module remkey_code_map
  import remkey_pkg::*;
(
  input  logic [BYTE_W-1:0] code,
  output logic              known,
  output logic [KEY_W-1:0]  key
);
  logic [KEY_W-1:0] low;
  logic             single;

  assign low    = code[KEY_W-1:0];
  assign single = (low != '0) && ((low & (low - 1'b1)) == '0);
  assign known  = (code[BYTE_W-1:KEY_W] == KEY_PREFIX) && single;
  assign key    = known ? low : '0;
endmodule

// File: rtl/remkey_gap_class.sv
module remkey_gap_class
  import remkey_pkg::*;
#(
  parameter int unsigned REPEAT_CYC = 25_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [KEY_W-1:0] hit_key,
  output logic             press,
  output logic             repeat_ev,
  output logic [KEY_W-1:0] key
);
  localparam int TW = $clog2(REPEAT_CYC + 1);
  localparam logic [TW-1:0] TMR_MAX = TW'(REPEAT_CYC);

  logic [TW-1:0]    tmr_q, tmr_n;
  logic [KEY_W-1:0] key_n;
  logic             press_n, rep_n;

  always_comb begin
    tmr_n   = (tmr_q == TMR_MAX) ? tmr_q : tmr_q + 1'b1;
    key_n   = key;
    press_n = 1'b0;
    rep_n   = 1'b0;
    if (hit) begin
      tmr_n = '0;
      key_n = hit_key;
      if (hit_key == key && tmr_q < TMR_MAX) rep_n   = 1'b1;
      else                                   press_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q     <= TMR_MAX;
      key       <= '0;
      press     <= 1'b0;
      repeat_ev <= 1'b0;
    end else begin
      tmr_q     <= tmr_n;
      key       <= key_n;
      press     <= press_n;
      repeat_ev <= rep_n;
    end
  end
endmodule

// File: rtl/remkey_decoder.sv
module remkey_decoder
  import remkey_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned BAUD       = 9600,
  parameter int unsigned REPEAT_CYC = CLK_HZ / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  output logic             key_press,
  output logic             key_repeat,
  output logic [KEY_W-1:0] key_onehot,
  output logic             frame_err
);
  localparam int unsigned TICK_DIV = CLK_HZ / (BAUD * OVS);

  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic [1:0]        rx_sync;
  logic              tick;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_data;
  logic              known;
  logic [KEY_W-1:0]  code_key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rx_sync <= '1;
    else          rx_sync <= {rx_sync[0], rx_line};
  end

  remkey_tick_gen #(.DIV(TICK_DIV)) tick_i (
    .clk  (clk),
    .rst_n(rst_i_n),
    .tick (tick)
  );

  remkey_uart_rx #(.DATA_W(BYTE_W)) rx_i (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tick     (tick),
    .rx       (rx_sync[1]),
    .byte_vld (byte_vld),
    .stop_err (frame_err),
    .byte_data(byte_data)
  );

  remkey_code_map map_i (
    .code (byte_data),
    .known(known),
    .key  (code_key)
  );

  remkey_gap_class #(.REPEAT_CYC(REPEAT_CYC)) gap_i (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .hit      (byte_vld & known),
    .hit_key  (code_key),
    .press    (key_press),
    .repeat_ev(key_repeat),
    .key      (key_onehot)
  );
endmodule

// File: rtl/remkey_decoder_chk.sv
module remkey_decoder_chk #(
  parameter int unsigned REPEAT_CYC = 25_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       key_press,
  input logic       key_repeat,
  input logic [5:0] key_onehot,
  input logic       frame_err
);
  logic [31:0] gap_q;
  logic        had_q;
  logic [5:0]  last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= REPEAT_CYC;
      had_q  <= 1'b0;
      last_q <= '0;
    end else if (key_press || key_repeat) begin
      gap_q  <= '0;
      had_q  <= 1'b1;
      last_q <= key_onehot;
    end else if (gap_q < REPEAT_CYC) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R8
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_press && key_repeat));

  // R8
  press_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_press |=> !key_press);

  // R8
  repeat_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_repeat |=> !key_repeat);

  // R8
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_press || key_repeat) |=> $stable(key_onehot) || key_press || key_repeat);

  // R3
  key_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(key_onehot));

  // R5
  ferr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !key_press && !key_repeat);

  // R6
  repeat_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_repeat |-> had_q && gap_q < REPEAT_CYC && key_onehot == last_q);

  // R7
  press_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_press && had_q && key_onehot == last_q) |-> gap_q >= REPEAT_CYC);
endmodule

bind remkey_decoder remkey_decoder_chk #(.REPEAT_CYC(REPEAT_CYC)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .key_press (key_press),
  .key_repeat(key_repeat),
  .key_onehot(key_onehot),
  .frame_err (frame_err)
);

// File: tb/remkey_decoder_tb_top.sv
module remkey_decoder_tb_top;
  localparam int unsigned CLK_HZ = 1_228_800;
  localparam int unsigned BAUD   = 9600;
  localparam int unsigned REP    = 3000;
  localparam int          BITC   = CLK_HZ / BAUD;
  localparam int          NVEC   = 16;

  // {code, stop, idle cycles, kind(0 none,1 press,2 repeat,3 ferr), expected key}
  localparam logic [32:0] VEC [NVEC] = '{
    {8'hC1, 1'b1, 16'd100,  2'd1, 6'h01},
    {8'hC1, 1'b1, 16'd200,  2'd2, 6'h01},
    {8'hC1, 1'b1, 16'd200,  2'd2, 6'h01},
    {8'hC2, 1'b1, 16'd200,  2'd1, 6'h02},
    {8'hC2, 1'b1, 16'd4000, 2'd1, 6'h02},
    {8'hC4, 1'b1, 16'd100,  2'd1, 6'h04},
    {8'hC8, 1'b1, 16'd100,  2'd1, 6'h08},
    {8'hD0, 1'b1, 16'd100,  2'd1, 6'h10},
    {8'hE0, 1'b1, 16'd100,  2'd1, 6'h20},
    {8'hE0, 1'b1, 16'd200,  2'd2, 6'h20},
    {8'h41, 1'b1, 16'd200,  2'd0, 6'h20},
    {8'hC3, 1'b1, 16'd200,  2'd0, 6'h20},
    {8'hE0, 1'b1, 16'd200,  2'd1, 6'h20},
    {8'hC1, 1'b0, 16'd200,  2'd3, 6'h20},
    {8'hC1, 1'b1, 16'd200,  2'd1, 6'h01},
    {8'hC1, 1'b1, 16'd200,  2'd2, 6'h01}
  };

  logic       clk;
  logic       rst_n;
  logic       rx_line;
  logic       key_press;
  logic       key_repeat;
  logic [5:0] key_onehot;
  logic       frame_err;

  int n_checks = 0;
  int n_fail   = 0;
  int n_press  = 0;
  int n_rep    = 0;
  int n_ferr   = 0;
  bit done     = 1'b0;

  remkey_decoder #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .REPEAT_CYC(REP)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_line   (rx_line),
    .key_press (key_press),
    .key_repeat(key_repeat),
    .key_onehot(key_onehot),
    .frame_err (frame_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (key_press)  n_press++;
      if (key_repeat) n_rep++;
      if (frame_err)  n_ferr++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic send_frame(input logic [7:0] code, input logic stop, input int idle,
                            input int glitch_bit);
    rx_line = 1'b1;
    repeat (idle) @(negedge clk);
    rx_line = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = code[i];
      if (i == glitch_bit) begin
        repeat (66) @(negedge clk);
        rx_line = ~code[i];
        repeat (8) @(negedge clk);
        rx_line = code[i];
        repeat (BITC - 74) @(negedge clk);
      end else begin
        repeat (BITC) @(negedge clk);
      end
    end
    rx_line = stop;
    repeat (BITC) @(negedge clk);
    rx_line = 1'b1;
    repeat (64) @(negedge clk);
  endtask

  // kind: 0 none, 1 press, 2 repeat, 3 framing error
  task automatic expect_event(input int kind, input int p0, input int r0, input int f0,
                              input string req);
    int got;
    got = ((n_press - p0) == 1 && (n_rep - r0) == 0 && (n_ferr - f0) == 0) ? 1 :
          ((n_press - p0) == 0 && (n_rep - r0) == 1 && (n_ferr - f0) == 0) ? 2 :
          ((n_press - p0) == 0 && (n_rep - r0) == 0 && (n_ferr - f0) == 1) ? 3 :
          ((n_press - p0) == 0 && (n_rep - r0) == 0 && (n_ferr - f0) == 0) ? 0 : 9;
    check(got == kind, req, got, kind);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    int p0, r0, f0;
    rst_n   = 1'b0;
    rx_line = 1'b1;
    repeat (5) @(negedge clk);
    // R9: reset state
    check(key_press == 1'b0 && key_repeat == 1'b0 && frame_err == 1'b0, "R9 reset pulses",
          {key_press, key_repeat, frame_err}, 0);
    check(key_onehot == 6'h00, "R9 reset key", key_onehot, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      p0 = n_press; r0 = n_rep; f0 = n_ferr;
      send_frame(VEC[v][32:25], VEC[v][24], int'(VEC[v][23:8]), -1);
      case (VEC[v][7:6])
        2'd0: tag = "R4 unknown code ignored";
        2'd1: tag = (v == 0) ? "R9 first press" : (v == 4) ? "R10 saturated gap press" :
                    (v == 12) ? "R4/R10 press after ignored" : "R7 press";
        2'd2: tag = "R6 repeat";
        default: tag = "R5 framing error";
      endcase
      expect_event(int'(VEC[v][7:6]), p0, r0, f0, tag);
      check(key_onehot == VEC[v][5:0], "R3 key identity", key_onehot, VEC[v][5:0]);
    end

    // R1: short low pulse on the idle line is not a start bit
    p0 = n_press; r0 = n_rep; f0 = n_ferr;
    rx_line = 1'b0;
    repeat (16) @(negedge clk);
    rx_line = 1'b1;
    repeat (2000) @(negedge clk);
    expect_event(0, p0, r0, f0, "R1 start glitch rejected");
    check(key_onehot == 6'h01, "R1 key unchanged", key_onehot, 6'h01);

    // R2: one-sample disturbance in bit 1 of 0xC1 is voted out
    p0 = n_press; r0 = n_rep; f0 = n_ferr;
    send_frame(8'hC1, 1'b1, 4000, 1);
    expect_event(1, p0, r0, f0, "R2 majority vote");
    check(key_onehot == 6'h01, "R2 key", key_onehot, 6'h01);

    // R6 then R9: repeat, then reset clears the memory
    p0 = n_press; r0 = n_rep; f0 = n_ferr;
    send_frame(8'hC1, 1'b1, 200, -1);
    expect_event(2, p0, r0, f0, "R6 repeat before reset");
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(key_onehot == 6'h00 && !key_press && !key_repeat, "R9 reset clears key",
          key_onehot, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    p0 = n_press; r0 = n_rep; f0 = n_ferr;
    send_frame(8'hC1, 1'b1, 100, -1);
    expect_event(1, p0, r0, f0, "R9 first press after reset");
    check(key_onehot == 6'h01, "R9 key after reset", key_onehot, 6'h01);

    done = 1'b1;
    summary();
  end
endmodule